// File: doc/BRIEF.md
# Serial Host Register Port

This block is a slave on a chip-select-framed synchronous serial link. It gives an external host access to a small internal register file. The host frames every byte with its own chip-select low window. The first byte of a transaction is an instruction. Its top bit selects direction and its lower seven bits name a register. The next window carries the data: the host shifts a value in for a write, or the block shifts the addressed value out for a read.

All serial pins are brought into the system clock domain through synchronizers, and all logic runs on that clock. A programmable timeout discards an instruction whose data byte arrives too late. Two further mechanisms return the port to the instruction phase after the host and block lose byte alignment: a reserved one-byte realign code, and any window that does not hold exactly eight bits. A fixed read-only code lets the host confirm that it is aligned.

Top module: `host_serial_port`

## Requirements
- R1: Bytes move MSB first. MOSI is sampled on rising serial-clock edges. In the instruction byte, bit 7 = 1 means read and bit 7 = 0 means write, and bits 6..0 give the register id.
- R2: A write instruction followed by a data byte in the next chip-select window stores that byte in general register id 00h..NREGS-1.
- R3: After a read instruction, the next window shifts the addressed value out on MISO, MSB first. The first bit is valid before the first rising serial-clock edge, and later bits advance after each falling edge. Output enable is high during that window.
- R4: Output enable is low at reset and whenever chip select has been high for three system clocks.
- R5: Id 40h reads the fixed code E4h, and writes to it have no effect.
- R6: Id 41h is the timeout register. It resets to FFh, can be read and written, and sets the limit to value×16 system clocks. The value 0 disables the timeout.
- R7: The timeout counter restarts at every chip-select falling edge and runs while a data byte is pending. When the count reaches the limit, the pending instruction is dropped, and the next byte is taken as a new instruction.
- R8: A byte of FFh received in any phase returns the port to the instruction phase and writes nothing.
- R9: A window holding a bit count other than eight is discarded and returns the port to the instruction phase, with no write.
- R10: Ids that are not mapped read 00h, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_cs_n | input | 1 | Active-low chip select, one byte per low window |
| ser_mosi | input | 1 | Serial data from host |
| ser_miso | output | 1 | Serial data to host |
| ser_miso_oe | output | 1 | Drive enable for ser_miso; the pin floats when low |

## Verification
The hardest situation to reach is a timeout rejection that leaves the host misaligned. In that case a late data byte is treated as an instruction, and the port then waits on a phantom data phase. The bench first programs a short limit. It then stretches the gap after a write instruction well beyond that limit and sends the late byte. Next it issues the realign code, and finally it reads the target back to show that nothing was written. Disabling the limit, a very long gap and truncated windows in both phases complete the recovery cases, and these directed steps are mixed with seeded random reads and writes.

// File: rtl/hsp_pkg.sv
`timescale 1ns/1ps
package hsp_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 7;
  localparam logic [ID_W-1:0]   SYNC_ID    = 7'h40;
  localparam logic [ID_W-1:0]   TMO_ID     = 7'h41;
  localparam logic [BYTE_W-1:0] SYNC_CODE  = 8'hE4;
  localparam logic [BYTE_W-1:0] TMO_RESET  = 8'hFF;
  localparam logic [BYTE_W-1:0] REALIGN    = 8'hFF;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2
  } phase_t;
endpackage

// File: rtl/hsp_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a bundle of asynchronous pins.
module hsp_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hsp_shifter.sv
`timescale 1ns/1ps
// Per-window byte shifter: receives on serial rising edges, transmits on falling edges.
module hsp_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_open,
  input  logic          win_start,
  input  logic          win_end,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic          load_en,
  input  logic [BW-1:0] load_byte,
  output logic [BW-1:0] rx_byte,
  output logic          byte_ok,
  output logic          byte_err,
  output logic          miso,
  output logic          miso_oe
);
  localparam int CNT_W = $clog2(BW + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(BW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BW);

  logic [CNT_W-1:0] bit_cnt;
  logic [BW-1:0]    tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      rx_byte  <= '0;
      tx_sh    <= '0;
      byte_ok  <= 1'b0;
      byte_err <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      byte_ok  <= 1'b0;
      byte_err <= 1'b0;
      miso_oe  <= win_open;
      if (win_start) begin
        bit_cnt <= '0;
        tx_sh   <= load_en ? load_byte : '0;
      end else if (win_open) begin
        if (sck_rise) begin
          rx_byte <= {rx_byte[BW-2:0], mosi_s};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_fall) tx_sh <= {tx_sh[BW-2:0], 1'b0};
      end
      if (win_end) begin
        if (bit_cnt == CNT_FULL) byte_ok  <= 1'b1;
        else                     byte_err <= 1'b1;
      end
    end
  end

  assign miso = tx_sh[BW-1];
endmodule

// File: rtl/hsp_regfile.sv
`timescale 1ns/1ps
// General registers in an inferable RAM, plus the check code and timeout limit.
module hsp_regfile
  import hsp_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ID_W-1:0]   addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] tmo_limit
);
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [BYTE_W-1:0] mem [NREGS];
  logic in_gen;

  assign in_gen = int'(addr) < NREGS;

  always_ff @(posedge clk) begin
    if (we && in_gen) mem[addr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_limit <= TMO_RESET;
    end else if (we && addr == TMO_ID) begin
      tmo_limit <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      if (in_gen)                rdata <= mem[addr[AW-1:0]];
      else if (addr == SYNC_ID)  rdata <= SYNC_CODE;
      else if (addr == TMO_ID)   rdata <= tmo_limit;
      else                       rdata <= '0;
    end
  end

  AST_SYNC_CODE: assert property (@(posedge clk) disable iff (rst)
    (re && addr == SYNC_ID) |=> rdata == SYNC_CODE); // R5
  AST_TMO_ONLY_BY_ID: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == TMO_ID) |=> $stable(tmo_limit)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (re && !in_gen && addr != SYNC_ID && addr != TMO_ID) |=> rdata == '0); // R10
endmodule

// File: rtl/host_serial_port.sv
`timescale 1ns/1ps
module host_serial_port
  import hsp_pkg::*;
#(
  parameter int NREGS    = 8,
  parameter int TO_SHIFT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_cs_n,
  input  logic ser_mosi,
  output logic ser_miso,
  output logic ser_miso_oe
);
  localparam int TC_W = BYTE_W + TO_SHIFT + 1;

  logic [2:0] pins_s;
  logic cs_n_s, sck_s, mosi_s;
  logic cs_n_d, sck_d;
  logic win_start, win_end, sck_rise, sck_fall;

  hsp_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({ser_cs_n, ser_clk, ser_mosi}), .q(pins_s)
  );
  assign {cs_n_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_d <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s;
      sck_d  <= sck_s;
    end
  end

  assign win_start = !cs_n_s &&  cs_n_d;
  assign win_end   =  cs_n_s && !cs_n_d;
  assign sck_rise  =  sck_s  && !sck_d;
  assign sck_fall  = !sck_s  &&  sck_d;

  phase_t            phase;
  logic [ID_W-1:0]   id_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              we_q, re_q;
  logic [BYTE_W-1:0] rx_byte, rdata, tmo_limit;
  logic              byte_ok, byte_err;
  logic [TC_W-1:0]   tmo_cnt, tmo_thr;
  logic              tmo_hit;

  hsp_shifter #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst(rst),
    .win_open(!cs_n_s), .win_start(win_start), .win_end(win_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .load_en(phase == PH_RDATA), .load_byte(rdata),
    .rx_byte(rx_byte), .byte_ok(byte_ok), .byte_err(byte_err),
    .miso(ser_miso), .miso_oe(ser_miso_oe)
  );

  hsp_regfile #(.NREGS(NREGS)) u_regs (
    .clk(clk), .rst(rst), .we(we_q), .re(re_q), .addr(id_q),
    .wdata(wdata_q), .rdata(rdata), .tmo_limit(tmo_limit)
  );

  assign tmo_thr = {1'b0, tmo_limit, {TO_SHIFT{1'b0}}};
  assign tmo_hit = (tmo_limit != '0) && (tmo_cnt >= tmo_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_cnt <= '0;
    end else if (win_start) begin
      tmo_cnt <= '0;
    end else if (phase != PH_INSTR && tmo_cnt != '1) begin
      tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_INSTR;
      id_q    <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (phase != PH_INSTR && tmo_hit) begin
        phase <= PH_INSTR;
      end else if (byte_err) begin
        phase <= PH_INSTR;
      end else if (byte_ok) begin
        if (rx_byte == REALIGN) begin
          phase <= PH_INSTR;
        end else begin
          unique case (phase)
            PH_INSTR: begin
              id_q <= rx_byte[ID_W-1:0];
              if (rx_byte[BYTE_W-1]) begin
                phase <= PH_RDATA;
                re_q  <= 1'b1;
              end else begin
                phase <= PH_WDATA;
              end
            end
            PH_WDATA: begin
              we_q    <= 1'b1;
              wdata_q <= rx_byte;
              phase   <= PH_INSTR;
            end
            default: phase <= PH_INSTR;
          endcase
        end
      end
    end
  end

  AST_WRITE_NEEDS_INSTR: assert property (@(posedge clk) disable iff (rst)
    we_q |-> $past(phase) == PH_WDATA); // R2
  AST_REALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (byte_ok && rx_byte == REALIGN) |=> (!we_q && phase == PH_INSTR)); // R8
  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_INSTR && tmo_hit) |=> (phase == PH_INSTR && !we_q)); // R7
  AST_SHORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    byte_err |=> (phase == PH_INSTR && !we_q)); // R9
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ser_cs_n && $past(ser_cs_n) && $past(ser_cs_n, 2) && $past(ser_cs_n, 3))
      |-> !ser_miso_oe); // R4
endmodule

// File: tb/tb_host_serial_port.sv
`timescale 1ns/1ps
module tb_host_serial_port;
  localparam int NREGS = 8;
  localparam int HALF  = 8;
  localparam int GAP   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;

  int errors = 0;
  int checks = 0;
  logic oe_all;
  logic [7:0] model [NREGS];
  logic [7:0] tmo_model = 8'hFF;

  always #2 clk = ~clk;

  host_serial_port #(.NREGS(NREGS), .TO_SHIFT(4)) dut (
    .clk(clk), .rst(rst), .ser_clk(sclk), .ser_cs_n(cs_n), .ser_mosi(mosi),
    .ser_miso(miso), .ser_miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic [6:0] id);
    if (int'(id) < NREGS) return model[id[2:0]];
    if (id == 7'h40) return 8'hE4;
    if (id == 7'h41) return tmo_model;
    return 8'h00;
  endfunction

  // one chip-select window; R1 MSB first, R3 miso sampled just before each rise
  task automatic xfer(input logic [7:0] tx, input int nbits, input int gap,
                      output logic [7:0] rx);
    rx = 8'h00;
    oe_all = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = miso;
      oe_all = oe_all & miso_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
    chk("R4 oe low between windows", {7'd0, miso_oe}, 8'h00);
  endtask

  task automatic wr(input logic [6:0] id, input logic [7:0] d, input int gap);
    logic [7:0] dummy;
    xfer({1'b0, id}, 8, gap, dummy);
    xfer(d, 8, GAP, dummy);
  endtask

  task automatic rd(input logic [6:0] id, output logic [7:0] d);
    logic [7:0] dummy;
    xfer({1'b1, id}, 8, GAP, dummy);
    xfer(8'h00, 8, GAP, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, dummy;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 oe low after reset", {7'd0, miso_oe}, 8'h00);

    rd(7'h41, v); chk("R6 timeout reset value", v, 8'hFF);
    chk("R3 oe high during read window", {7'd0, oe_all}, 8'h01);
    rd(7'h40, v); chk("R5 check code", v, 8'hE4);

    // R2 directed fill, distinct bit patterns
    for (int i = 0; i < NREGS; i++) begin
      model[i] = 8'(8'h11 * i + 8'h01) ^ 8'h80;
      wr(7'(i), model[i], GAP);
    end
    for (int i = 0; i < NREGS; i++) begin
      rd(7'(i), v); chk("R2 R1 write then read", v, model[i]);
    end

    // R5 writes to check code ignored
    wr(7'h40, 8'h00, GAP);
    rd(7'h40, v); chk("R5 read-only after write", v, 8'hE4);

    // R10 unmapped id
    wr(7'h55, 8'h3C, GAP);
    rd(7'h55, v); chk("R10 unmapped reads zero", v, 8'h00);

    // R8 realign in data phase: no write
    xfer({1'b0, 7'h2}, 8, GAP, dummy);
    xfer(8'hFF, 8, GAP, dummy);
    rd(7'h2, v); chk("R8 realign writes nothing", v, model[2]);

    // R9 short window in instruction phase, then in data phase
    xfer(8'h03, 5, GAP, dummy);
    wr(7'h1, 8'hA5, GAP); model[1] = 8'hA5;
    rd(7'h1, v); chk("R9 short window ignored", v, 8'hA5);
    xfer({1'b0, 7'h1}, 8, GAP, dummy);
    xfer(8'h00, 6, GAP, dummy);
    rd(7'h1, v); chk("R9 short data window no write", v, 8'hA5);

    // R6 program timeout to 16 -> 256 clocks
    wr(7'h41, 8'h10, GAP); tmo_model = 8'h10;
    rd(7'h41, v); chk("R6 timeout readback", v, 8'h10);
    wr(7'h3, 8'h6B, GAP); model[3] = 8'h6B;
    rd(7'h3, v); chk("R7 short gap accepted", v, 8'h6B);

    // R7 late data byte after a write instruction is rejected
    xfer({1'b0, 7'h3}, 8, 400, dummy);
    xfer(8'h3C, 8, GAP, dummy);   // now taken as a new instruction
    xfer(8'hFF, 8, GAP, dummy);   // R8 recover framing
    rd(7'h3, v); chk("R7 late data rejected", v, 8'h6B);

    // R6 zero disables timeout
    wr(7'h41, 8'h00, GAP); tmo_model = 8'h00;
    wr(7'h4, 8'h2D, 5000); model[4] = 8'h2D;
    rd(7'h4, v); chk("R6 timeout disabled", v, 8'h2D);

    // random traffic, R2 R3 R10
    for (int n = 0; n < 60; n++) begin
      logic [6:0] id;
      logic [7:0] d;
      if ($urandom_range(0, 9) < 8) id = 7'($urandom_range(0, NREGS - 1));
      else id = 7'($urandom_range(8, 126));
      d = 8'($urandom_range(0, 254));
      if ($urandom_range(0, 1) == 1 && id != 7'h41) begin
        wr(id, d, GAP);
        if (int'(id) < NREGS) model[id[2:0]] = d;
      end else begin
        rd(id, v); chk("R3 random read", v, expect_rd(id));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule